// File: doc/BRIEF.md
# Trigger-Gated Pulse Timer

This block produces a single output pulse that follows a trigger level for a bounded time. When the trigger goes high, the output rises and an elapsed-time count starts from zero. The count advances once for every cycle in which the time-base tick enable is high. The pulse ends at whichever of two events comes first:

- the count reaches the preset duration, or
- the trigger goes low again.

A trigger that stays high after its pulse has timed out does not start a second pulse. A new pulse needs the trigger to fall and then rise again.

The preset duration is captured at the moment the trigger rises. Changing it while a pulse is running has no effect on that pulse. Both outputs are registered. A trigger level seen at a clock edge reaches the output at that same edge, so a rise and a drop of the trigger show up with the same one-register latency.

Top module: `tgp_timer`

## Requirements
- R1: Synchronous reset drives `pulse_o` and `elapsed_o` to 0 and clears the stored trigger. A trigger held high through reset is therefore treated as a new rise at the first edge after reset is released.
- R2: At an edge where `trig_in` is 1 and the stored trigger is 0, with a nonzero `preset_in`, `pulse_o` becomes 1 and `elapsed_o` becomes 0. A tick in that same cycle is not counted.
- R3: While a pulse is running, `elapsed_o` increases by exactly 1 at each edge where `tick_en` is 1. It holds its value at each edge where `tick_en` is 0.
- R4: At the edge where `elapsed_o` reaches the captured preset, `pulse_o` becomes 0. From then on, `elapsed_o` holds the preset value for as long as `trig_in` stays 1.
- R5: At any edge where `trig_in` is 0, `pulse_o` and `elapsed_o` both become 0, whatever the value of `tick_en`.
- R6: After a pulse has ended, a trigger that stays at 1 keeps `pulse_o` at 0 and `elapsed_o` unchanged. A new pulse requires `trig_in` to go to 0 and then back to 1.
- R7: A rise of the trigger with `preset_in` equal to 0 produces no pulse: `pulse_o` stays 0 and `elapsed_o` stays 0.
- R8: The preset is sampled at the rise of the trigger. Changes to `preset_in` during a pulse alter neither its length nor `elapsed_o`.
- R9: When the trigger drops in the same cycle as the tick that would end the pulse, the drop wins: `pulse_o` becomes 0 and `elapsed_o` becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Time-base enable; one unit of elapsed time per high cycle |
| trig_in | input | 1 | Trigger level |
| preset_in | input | CNT_W | Pulse duration in ticks, sampled at trigger rise |
| pulse_o | output | 1 | Registered pulse output |
| elapsed_o | output | CNT_W | Registered elapsed-time count |

## Verification
Two functions can act at the same edge:

- **Trigger drop and final tick.** The timeout that ends a pulse on its final tick can coincide with the trigger drop that clears everything. The bench provokes this by lowering `trig_in` in exactly the cycle that carries the last `tick_en` of a pulse. It expects the output low and the count at zero, rather than at the preset value.
- **Trigger rise and tick.** A rise can coincide with a tick. The bench judges that case by expecting the count to start at zero rather than one.

A scoreboard model built from the requirements predicts both outputs for every driven cycle.

// File: rtl/tgp_pkg.sv
package tgp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } tgp_state_t;
endpackage

// File: rtl/tgp_edge.sv
module tgp_edge (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;

  // R1: after reset the stored level is low, so a held trigger reads as a rise
  p_rise_after_reset_r1: assert property (@(posedge clk)
    $fell(rst) |-> (level_i == rise_o));
endmodule

// File: rtl/tgp_count.sv
module tgp_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic [CNT_W-1:0] elapsed_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] elapsed_q;
  logic [CNT_W-1:0] limit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed_q <= CNT_ZERO;
      limit_q   <= CNT_ZERO;
    end else if (clr_i) begin
      elapsed_q <= CNT_ZERO;
    end else if (load_i) begin
      elapsed_q <= CNT_ZERO;
      limit_q   <= preset_i;
    end else if (step_i) begin
      elapsed_q <= elapsed_q + CNT_ONE;
    end
  end

  assign elapsed_o = elapsed_q;
  assign last_o    = ((elapsed_q + CNT_ONE) == limit_q);

  // R3: a step adds exactly one
  p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
    (step_i && !clr_i && !load_i) |=> (elapsed_q == $past(elapsed_q) + CNT_ONE));

  // R3: without step, clear or load, the count holds
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !clr_i && !load_i) |=> $stable(elapsed_q));

  // R4: the count never passes the captured limit
  p_bound_r4: assert property (@(posedge clk) disable iff (rst)
    elapsed_q <= limit_q);

  // R8: the captured limit changes only on a load
  p_limit_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(limit_q));
endmodule

// File: rtl/tgp_ctrl.sv
module tgp_ctrl
  import tgp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  input  logic rise_i,
  input  logic tick_i,
  input  logic preset_zero_i,
  input  logic last_i,
  output logic clr_o,
  output logic load_o,
  output logic step_o,
  output logic pulse_o
);
  tgp_state_t state_q, state_d;
  logic       pulse_q, pulse_d;

  always_comb begin
    state_d = state_q;
    pulse_d = pulse_q;
    clr_o   = 1'b0;
    load_o  = 1'b0;
    step_o  = 1'b0;
    if (!trig_i) begin
      state_d = ST_IDLE;
      pulse_d = 1'b0;
      clr_o   = 1'b1;
    end else if (rise_i) begin
      load_o  = 1'b1;
      state_d = preset_zero_i ? ST_DONE : ST_RUN;
      pulse_d = !preset_zero_i;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (tick_i) begin
            step_o = 1'b1;
            if (last_i) begin
              state_d = ST_DONE;
              pulse_d = 1'b0;
            end
          end
        end
        ST_DONE: pulse_d = 1'b0;
        default: pulse_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

  // R2: a rise with a nonzero preset starts the pulse
  p_rise_starts_r2: assert property (@(posedge clk) disable iff (rst)
    (rise_i && !preset_zero_i) |=> pulse_q);

  // R5: a low trigger ends any pulse at the next edge
  p_drop_ends_r5: assert property (@(posedge clk) disable iff (rst)
    !trig_i |=> !pulse_q);

  // R6: no pulse restarts without a fresh rise
  p_no_retrigger_r6: assert property (@(posedge clk) disable iff (rst)
    (!rise_i && !pulse_q) |=> !pulse_q);

  // R7: zero preset gives no pulse
  p_zero_preset_r7: assert property (@(posedge clk) disable iff (rst)
    (rise_i && preset_zero_i) |=> !pulse_q);
endmodule

// File: rtl/tgp_timer.sv
module tgp_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             trig_in,
  input  logic [CNT_W-1:0] preset_in,
  output logic             pulse_o,
  output logic [CNT_W-1:0] elapsed_o
);
  logic rise;
  logic clr;
  logic load;
  logic step;
  logic last;
  logic preset_zero;

  assign preset_zero = (preset_in == '0);

  tgp_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .level_i (trig_in),
    .rise_o  (rise)
  );

  tgp_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .trig_i        (trig_in),
    .rise_i        (rise),
    .tick_i        (tick_en),
    .preset_zero_i (preset_zero),
    .last_i        (last),
    .clr_o         (clr),
    .load_o        (load),
    .step_o        (step),
    .pulse_o       (pulse_o)
  );

  tgp_count #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (clr),
    .load_i    (load),
    .step_i    (step),
    .preset_i  (preset_in),
    .elapsed_o (elapsed_o),
    .last_o    (last)
  );

  // R1: reset leaves both outputs at zero
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!pulse_o && elapsed_o == '0));

  // R9: a drop coinciding with any tick still clears the count
  p_drop_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (!trig_in && tick_en) |=> (elapsed_o == '0));
endmodule

// File: tb/tgp_timer_tb.sv
module tgp_timer_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         tick_en;
  logic         trig_in;
  logic [W-1:0] preset_in;
  logic         pulse_o;
  logic [W-1:0] elapsed_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic         q;
    logic [W-1:0] el;
    string        tag;
  } exp_t;
  exp_t sb[$];

  // reference state
  logic         m_q, m_prev;
  logic [W-1:0] m_el, m_lim;

  always #4 clk = ~clk;

  tgp_timer #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .trig_in(trig_in),
    .preset_in(preset_in), .pulse_o(pulse_o), .elapsed_o(elapsed_o)
  );

  task automatic drive(input logic t, input logic k, input logic [W-1:0] p, input string tag);
    exp_t e;
    @(negedge clk);
    trig_in = t; tick_en = k; preset_in = p;
    if (!t) begin
      m_q = 1'b0; m_el = '0;
    end else if (!m_prev) begin
      m_lim = p; m_el = '0; m_q = (p != '0);
    end else if (m_q && k) begin
      m_el = m_el + 1'b1;
      if (m_el == m_lim) m_q = 1'b0;
    end
    m_prev = t;
    e.q = m_q; e.el = m_el; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare after each active edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (pulse_o !== e.q || elapsed_o !== e.el) begin
        errors++;
        $display("FAIL %s: got q=%0b el=%0d expected q=%0b el=%0d",
                 e.tag, pulse_o, elapsed_o, e.q, e.el);
      end
    end
  end

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: got hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; trig_in = 1'b1; tick_en = 1'b1; preset_in = W'(3);
    m_q = 0; m_prev = 0; m_el = '0; m_lim = '0;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (pulse_o !== 1'b0 || elapsed_o !== '0) begin
      errors++;
      $display("FAIL R1: got q=%0b el=%0d expected q=0 el=0", pulse_o, elapsed_o);
    end
    @(negedge clk); rst = 1'b0; trig_in = 1'b1; tick_en = 1'b0;
    // first edge after reset: held trigger counts as a rise (R1)
    m_prev = 1'b0;
    m_lim = W'(3); m_el = '0; m_q = 1'b1; m_prev = 1'b1;
    begin
      exp_t e; e.q = 1'b1; e.el = '0; e.tag = "R1"; sb.push_back(e);
    end
    // run to timeout (R3, R4)
    drive(1, 1, 3, "R3");
    drive(1, 0, 3, "R3");
    drive(1, 1, 3, "R3");
    drive(1, 1, 3, "R4");
    // held high after timeout (R6)
    drive(1, 1, 3, "R6");
    drive(1, 1, 9, "R6");
    drive(1, 0, 9, "R6");
    // drop clears (R5)
    drive(0, 1, 3, "R5");
    drive(0, 0, 3, "R5");
    // rise coinciding with tick (R2), slow ticks, then drop mid-pulse (R5)
    drive(1, 1, 5, "R2");
    drive(1, 0, 5, "R3");
    drive(1, 1, 5, "R3");
    drive(1, 0, 5, "R3");
    drive(1, 1, 5, "R3");
    drive(0, 1, 5, "R5");
    drive(0, 0, 5, "R5");
    // zero preset (R7)
    drive(1, 1, 0, "R7");
    drive(1, 1, 0, "R7");
    drive(1, 1, 4, "R7");
    drive(0, 0, 4, "R7");
    // preset changed during pulse (R8)
    drive(1, 0, 4, "R8");
    drive(1, 1, 1, "R8");
    drive(1, 1, 1, "R8");
    drive(1, 1, 9, "R8");
    drive(1, 1, 9, "R8");
    drive(1, 1, 9, "R8");
    drive(0, 0, 9, "R8");
    // drop on the final tick (R9)
    drive(1, 0, 2, "R9");
    drive(1, 1, 2, "R9");
    drive(0, 1, 2, "R9");
    drive(0, 0, 2, "R9");
    // retrigger after a fresh low (R6)
    drive(1, 0, 2, "R6");
    drive(1, 1, 2, "R6");
    drive(1, 1, 2, "R6");
    drive(0, 0, 2, "R6");
    repeat (3) @(posedge clk);
    #3;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule